// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block produces the integer divide ratio that a fractional-N synthesizer's feedback divider uses on each phase-detector comparison. Software-facing settings (an 8-bit integer part, a 12-bit channel fraction and a signed 11-bit fine correction) are merged with a signed modulation offset from a keying block into one 15-bit fraction. A third-order noise-shaping modulator of three cascaded accumulators then turns that fraction into a stream of small offsets, from -3 to +4, which are added to the integer part. Over many comparisons the mean divide ratio equals the integer part plus the fraction divided by 2^15.

Each comparison is marked by a one-cycle strobe. All settings are sampled together on that strobe, so no divide value is ever formed from a mix of old and new settings. A merged fraction that would leave the range 0 to 32767 is clamped and a sticky flag records the event. An integer part below the prescaler's lowest legal value is raised to that value.

Top module: `frac_divctl`

## Requirements
- R1: While rst is high and in the cycle after it falls, div_out is 0 and sat_flag is 0; all accumulators and delay stages start at zero.
- R2: The merged fraction is chan_frac*8 + corr + mod_off, with corr and mod_off read as two's complement, clamped to the range 0 to 32767.
- R3: Every divide value equals the captured integer part plus an offset in the range -3 to +4.
- R4: With constant settings, the sum of div_out over 32768 consecutive strobes differs from 32768*integer + fraction by at most 3.
- R5: With a merged fraction of 0 and a cleared modulator, div_out equals the integer part exactly on every strobe.
- R6: Inputs are sampled only on a cycle with tick high; div_out changes only on such cycles, and settings applied before strobe k first appear in div_out after strobe k+1.
- R7: An integer part below P*P+3P+3 (31 for the default P of 4) is used as that minimum value.
- R8: sat_flag goes high on the strobe that captures a clamped fraction and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One strobe per phase-detector comparison |
| int_part | input | 8 | Integer part of the divide ratio |
| chan_frac | input | 12 | Channel fraction, weight 2^-12 |
| corr | input | 11 | Signed fine correction, weight 2^-15 |
| mod_off | input | 12 | Signed modulation offset, weight 2^-15 |
| div_out | output | 9 | Divide ratio for the current comparison |
| sat_flag | output | 1 | Sticky fraction clamp indicator |

## Verification
A corrupted accumulator or a wrong carry weight in the cancellation network leaves every single divide value plausible but shifts the mean, so the bench sums 32768 strobes per setting and compares the total with the exact expected count; an error of a few fraction LSBs shows within one such window. A wrong merge or clamp shows the same way, and also in the sticky flag on the very strobe that captures the setting. A capture or hold fault shows within one or two strobes as a divide value that tracks an input without a strobe or takes effect one strobe early.

// File: rtl/divctl_pkg.sv
package divctl_pkg;
  localparam int OFF_W = 4;
  typedef logic signed [OFF_W-1:0] off_t;
  localparam int STAGES = 3;
endpackage

// File: rtl/divctl_frac_merge.sv
module divctl_frac_merge #(
  parameter int FW = 15,
  parameter int CW = 12,
  parameter int EW = 11,
  parameter int MW = 12
) (
  input  logic [CW-1:0] chan_frac,
  input  logic [EW-1:0] corr,
  input  logic [MW-1:0] mod_off,
  output logic [FW-1:0] frac,
  output logic          clamped
);
  localparam int SHIFT = FW - CW;
  localparam int RW    = FW + 2;
  localparam logic signed [RW-1:0] MAXV = (1 <<< FW) - 1;

  logic signed [RW-1:0] chan_x, corr_x, mod_x, raw;

  always_comb begin
    chan_x = {{(RW-FW){1'b0}}, chan_frac, {SHIFT{1'b0}}};
    corr_x = {{(RW-EW){corr[EW-1]}}, corr};
    mod_x  = {{(RW-MW){mod_off[MW-1]}}, mod_off};
    raw    = chan_x + corr_x + mod_x;
    clamped = 1'b0;
    if (raw < 0) begin
      frac    = '0;
      clamped = 1'b1;
    end else if (raw > MAXV) begin
      frac    = '1;
      clamped = 1'b1;
    end else begin
      frac = raw[FW-1:0];
    end
  end
endmodule

// File: rtl/divctl_acc_stage.sv
module divctl_acc_stage #(
  parameter int FW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [FW-1:0] add,
  output logic [FW-1:0] nxt,
  output logic          carry
);
  logic [FW-1:0] acc;

  always_comb {carry, nxt} = {1'b0, acc} + {1'b0, add};

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (adv) acc <= nxt;
  end
endmodule

// File: rtl/divctl_noise_cancel.sv
module divctl_noise_cancel
  import divctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [STAGES-1:0] c,
  output off_t              off
);
  logic c2d, c3d, c3dd;

  always_comb begin
    off = off_t'({3'b000, c[0]}) + off_t'({3'b000, c[1]}) - off_t'({3'b000, c2d})
        + off_t'({3'b000, c[2]}) - off_t'({2'b00, c3d, 1'b0}) + off_t'({3'b000, c3dd});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c2d  <= 1'b0;
      c3d  <= 1'b0;
      c3dd <= 1'b0;
    end else if (adv) begin
      c2d  <= c[1];
      c3d  <= c[2];
      c3dd <= c3d;
    end
  end

  // R3
  offset_range_chk: assert property (@(posedge clk) disable iff (rst)
    adv |-> (off >= -3 && off <= 4));
endmodule

// File: rtl/frac_divctl.sv
module frac_divctl
  import divctl_pkg::*;
#(
  parameter int IW = 8,
  parameter int FW = 15,
  parameter int CW = 12,
  parameter int EW = 11,
  parameter int MW = 12,
  parameter int PSC_P = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [IW-1:0] int_part,
  input  logic [CW-1:0] chan_frac,
  input  logic [EW-1:0] corr,
  input  logic [MW-1:0] mod_off,
  output logic [IW:0]   div_out,
  output logic          sat_flag
);
  localparam int MIN_INT = PSC_P * PSC_P + 3 * PSC_P + 3;
  localparam logic [IW-1:0] MIN_V = IW'(MIN_INT);

  logic [FW-1:0] frac_now, frac_q;
  logic          clamp_now;
  logic [IW-1:0] int_q, int_lim;
  logic [FW-1:0] stage_in  [STAGES];
  logic [FW-1:0] stage_nxt [STAGES];
  logic [STAGES-1:0] carries;
  off_t          off;

  divctl_frac_merge #(.FW(FW), .CW(CW), .EW(EW), .MW(MW)) i_merge (
    .chan_frac(chan_frac), .corr(corr), .mod_off(mod_off),
    .frac(frac_now), .clamped(clamp_now)
  );

  always_comb int_lim = (int_part < MIN_V) ? MIN_V : int_part;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q    <= MIN_V;
      frac_q   <= '0;
      sat_flag <= 1'b0;
    end else if (tick) begin
      int_q  <= int_lim;
      frac_q <= frac_now;
      if (clamp_now) sat_flag <= 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign stage_in[g] = frac_q;
      end else begin : g_rest
        assign stage_in[g] = stage_nxt[g-1];
      end
      divctl_acc_stage #(.FW(FW)) i_acc (
        .clk(clk), .rst(rst), .adv(tick),
        .add(stage_in[g]), .nxt(stage_nxt[g]), .carry(carries[g])
      );
    end
  endgenerate

  divctl_noise_cancel i_cancel (
    .clk(clk), .rst(rst), .adv(tick), .c(carries), .off(off)
  );

  always_ff @(posedge clk) begin
    if (rst)       div_out <= '0;
    else if (tick) div_out <= {1'b0, int_q} + {{(IW+1-OFF_W){off[OFF_W-1]}}, off};
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(div_out));
  // R8
  sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sat_flag) |-> sat_flag);
  // R8
  sat_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && clamp_now) |=> sat_flag);
  // R7
  min_int_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (div_out >= (IW+1)'(MIN_INT - 3)));
endmodule

// File: tb/test_frac_divctl.sv
module test_frac_divctl;
  logic clk = 1'b0;
  logic rst, tick;
  logic [7:0]  int_part;
  logic [11:0] chan_frac;
  logic [10:0] corr;
  logic [11:0] mod_off;
  logic [8:0]  div_out;
  logic        sat_flag;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frac_divctl i_frac_divctl (
    .clk(clk), .rst(rst), .tick(tick), .int_part(int_part),
    .chan_frac(chan_frac), .corr(corr), .mod_off(mod_off),
    .div_out(div_out), .sat_flag(sat_flag)
  );

  function automatic int exp_frac(int ch, int co, int mo);
    int v;
    v = ch * 8 + co + mo;
    if (v < 0) v = 0;
    if (v > 32767) v = 32767;
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_in(int ip, int ch, int co, int mo);
    int_part  = 8'(ip);
    chan_frac = 12'(ch);
    corr      = 11'(co);
    mod_off   = 12'(mo);
  endtask

  task automatic window(int ip, int ch, int co, int mo);
    longint sum, expv, diff;
    int bad;
    sum = 0; bad = 0;
    set_in(ip, ch, co, mo);
    edge_n(2);
    for (int i = 0; i < 32768; i++) begin
      sum += div_out;
      if (int'(div_out) < ip - 3 || int'(div_out) > ip + 4) bad++;
      @(negedge clk);
    end
    check("R3 out-of-range samples", bad, 0);
    expv = 64'd32768 * ip + exp_frac(ch, co, mo);
    diff = sum - expv;
    if (diff < 0) diff = -diff;
    checks++;
    if (diff > 3) begin
      fails++;
      $display("FAIL R4/R2 sum actual=%0d expected=%0d", sum, expv);
    end
  endtask

  initial begin
    while (!done && cycles < 198000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int ip, ch, co, mo, seed;
    seed = $urandom(32'h5eed);
    rst = 1'b1; tick = 1'b0;
    set_in(100, 0, 0, 0);
    edge_n(3);
    check("R1 div_out in reset", div_out, 0);
    check("R1 sat_flag in reset", sat_flag, 0);
    rst = 1'b0;
    edge_n(1);
    check("R1 div_out after reset", div_out, 0);

    tick = 1'b1;
    edge_n(2);
    for (int i = 0; i < 8; i++) begin
      check("R5 zero fraction exact", div_out, 100);
      edge_n(1);
    end

    tick = 1'b0;
    int_part = 8'd120;
    for (int i = 0; i < 4; i++) begin
      edge_n(1);
      check("R6 hold without tick", div_out, 100);
    end
    tick = 1'b1;
    edge_n(1);
    check("R6 first strobe keeps old", div_out, 100);
    edge_n(1);
    check("R6 second strobe applies new", div_out, 120);

    int_part = 8'd10;
    edge_n(2);
    check("R7 integer clamp to minimum", div_out, 31);
    check("R8 no clamp yet", sat_flag, 0);

    for (int k = 0; k < 2; k++) begin
      ip = 31 + int'($urandom_range(224));
      ch = 256 + int'($urandom_range(3544));
      co = int'($urandom_range(2047)) - 1024;
      mo = int'($urandom_range(400)) - 200;
      window(ip, ch, co, mo);
    end
    window(77, 1000, -7, 200);
    check("R8 flag low without clamp", sat_flag, 0);

    set_in(200, 4095, 100, 0);
    edge_n(1);
    check("R8 flag on clamping strobe", sat_flag, 1);
    window(200, 4095, 100, 0);

    window(150, 0, -40, -10);
    check("R8 flag sticky", sat_flag, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule